// File: doc/BRIEF.md
# Mode-switched indexed register interface

This block is the host-facing register front end of an audio codec. The host reaches it through four consecutive I/O locations on an ISA-style parallel bus. One location holds an index pointer, and the location beside it is a data port that reads or writes the indexed register the pointer selects. The other two locations are plain latches: a status byte and a direct data byte. The base of the four locations comes in on an input. A cycle counts only when the address matches that base and the address-enable line is low.

A two-bit compatibility field in indexed register 12 chooses how many registers the host can see. In the base map only the low four index bits are decoded, so sixteen registers are visible. In the wide map a fifth index bit opens registers 16 to 31. The extended map keeps the wide map and adds a second bank of 32 registers. The host reaches that bank by arming indexed register 23 as a window. When the block drops back from a larger map to the base map, it clears four registers and leaves every other register unchanged.

Bus cycles go through a four-state machine. `BUS_IDLE` waits for a decoded strobe. `BUS_IDLE -> BUS_READ` happens on a decoded read strobe, and `BUS_READ -> BUS_IDLE` happens when that strobe is released. `BUS_IDLE -> BUS_WLOW` happens on a decoded write strobe, and the machine captures write data while the strobe stays low. `BUS_WLOW -> BUS_COMMIT` happens when the strobe rises. `BUS_COMMIT -> BUS_IDLE` always follows one cycle later, and the register update lands on that edge.

Top module: `codec_regif`

## Requirements
- R1: While reset is active and after it is released, `rdata_oe` is low. The index, status and direct latches read 0, every indexed and extended register is 0, and the block is in the base map.
- R2: A cycle is decoded only when `aen` is 0 and `bus_addr` matches `base_addr` in every bit except bits 1:0. `base_addr` bits 1:0 are ignored. Strobes on an undecoded cycle leave `rdata_oe` low and change no register.
- R3: A decoded `rd_n` low that is sampled at a clock edge raises `rdata_oe` after that edge. `rdata_oe` stays high, with `rdata` showing the selected register, until the edge that samples `rd_n` high, and falls after that edge.
- R4: A write is committed only after the block samples `wr_n` rising. The value stored is the last `wdata` sampled while `wr_n` was low. Data that changes together with the rising strobe is not stored.
- R5: Offsets from the base are 0 = index pointer, 1 = indexed data port, 2 = status latch and 3 = direct data latch. Each is 8 bits and reads back what was written.
- R6: Bits 7:6 of indexed register 12 form the mode field. 00 and 01 select the base map, 10 selects the wide map and 11 selects the extended map. The field reads back as written, including 01.
- R7: In the base map the data port selects an indexed register with index-pointer bits 3:0 only, so pointer 0x13 reaches register 3. The pointer reads back all 8 bits as written.
- R8: In the wide and extended maps the data port selects with pointer bits 4:0, reaching registers 0 to 31. Pointer bits 7:5 are ignored.
- R9: A data-port write to register 12 that moves the map from wide or extended to base, with a written field of 00 or 01, clears indexed registers 24, 28, 30 and 31 on the same edge. All other registers keep their values.
- R10: In the extended map, a data-port write to register 23 with bit 7 set arms the window, and bits 4:0 of register 23 pick an extended register. The next data-port access, read or write, goes to that extended register instead of register 23. The window is then disarmed. Register 23 keeps the value written to it.
- R11: Outside the extended map, or when bit 7 is clear, a write to register 23 is plain storage. The following data-port accesses reach register 23 itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Host I/O address |
| base_addr | input | ADDR_W | Base of the four-location block; bits 1:0 ignored |
| aen | input | 1 | Address enable; a cycle is valid only while low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; data committed after its rising edge |
| wdata | input | DATA_W | Host write data |
| rdata | output | DATA_W | Read data; zero while not driving |
| rdata_oe | output | 1 | High while the block drives the data bus |

## Verification
A corrupted index pointer or mode field shows up on the first data-port read after it: that read returns a register from the wrong bank or the wrong half of the map. A missed or extra clear shows up as soon as the wide map is entered again and registers 24, 25, 28, 30 or 31 are read back. A window flag that does not clear makes the read straight after the extended access return extended data instead of register 23. A stuck bus state shows within two clock edges, because `rdata_oe` fails to rise or fall.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;

    typedef enum logic [1:0] {
        MAP_BASE = 2'd0,
        MAP_WIDE = 2'd1,
        MAP_EXT  = 2'd2
    } map_mode_e;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_READ   = 2'd1,
        BUS_WLOW   = 2'd2,
        BUS_COMMIT = 2'd3
    } bus_state_e;

    localparam logic [1:0] OFF_INDEX  = 2'd0;
    localparam logic [1:0] OFF_DATA   = 2'd1;
    localparam logic [1:0] OFF_STAT   = 2'd2;
    localparam logic [1:0] OFF_DIRECT = 2'd3;

    localparam int MODE_REG_IDX   = 12;
    localparam int WIN_REG_IDX    = 23;
    localparam int MODE_FIELD_LSB = 6;
    localparam int WIN_ARM_BIT    = 7;

    // registers 24, 28, 30, 31 are cleared when falling back to the base map
    localparam logic [31:0] CLR_ON_BASE = 32'hD100_0000;

    function automatic map_mode_e decode_map(input logic [1:0] fld);
        map_mode_e m;
        unique case (fld)
            2'b10:   m = MAP_WIDE;
            2'b11:   m = MAP_EXT;
            default: m = MAP_BASE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/codec_regif_bus_fsm.sv
module codec_regif_bus_fsm
    import codec_regif_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              aen,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wdata,
    output logic              drive_en,
    output logic [1:0]        cur_off,
    output logic              commit,
    output logic              rd_done,
    output logic [DATA_W-1:0] wr_val
);

    localparam logic [ADDR_W-1:0] SLOT_MASK = ~ADDR_W'(3);

    bus_state_e        st_q, st_d;
    logic [1:0]        off_q;
    logic [DATA_W-1:0] data_q;
    logic              addr_hit;
    logic [ADDR_W-1:0] addr_diff;

    assign addr_diff = (bus_addr ^ base_addr) & SLOT_MASK;
    assign addr_hit  = !aen && (addr_diff == '0);

    // next-state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_IDLE: begin
                if (addr_hit && !rd_n)      st_d = BUS_READ;
                else if (addr_hit && !wr_n) st_d = BUS_WLOW;
            end
            BUS_READ:   if (rd_n) st_d = BUS_IDLE;
            BUS_WLOW:   if (wr_n) st_d = BUS_COMMIT;
            BUS_COMMIT: st_d = BUS_IDLE;
            default:    st_d = BUS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BUS_IDLE;
        else        st_q <= st_d;
    end

    // offset and write-data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q  <= '0;
            data_q <= '0;
        end else begin
            if (st_q == BUS_IDLE && addr_hit && (!rd_n || !wr_n))
                off_q <= bus_addr[1:0];
            if ((st_q == BUS_IDLE && addr_hit && rd_n && !wr_n) ||
                (st_q == BUS_WLOW && !wr_n))
                data_q <= wdata;
        end
    end

    // outputs
    always_comb begin
        drive_en = 1'b0;
        commit   = 1'b0;
        rd_done  = 1'b0;
        unique case (st_q)
            BUS_READ: begin
                drive_en = 1'b1;
                rd_done  = rd_n;
            end
            BUS_COMMIT: commit = 1'b1;
            default: ;
        endcase
    end

    assign cur_off = off_q;
    assign wr_val  = data_q;

endmodule

// File: rtl/codec_regif_bank.sv
module codec_regif_bank
    import codec_regif_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_IDX  = 32,
    parameter int N_X    = 32,
    parameter int IDX_W  = $clog2(N_IDX),
    parameter int XSEL_W = $clog2(N_X)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [1:0]        off,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              redirect,
    output logic [DATA_W-1:0] rd_val,
    output map_mode_e         mode,
    output logic [IDX_W-1:0]  eff_idx,
    output logic [XSEL_W-1:0] win_sel
);

    localparam int BASE_W = IDX_W - 1;

    logic [DATA_W-1:0] index_q, stat_q, direct_q;
    logic [DATA_W-1:0] ireg_q [N_IDX];
    logic              dp_wr, leaving;

    assign mode    = decode_map(ireg_q[MODE_REG_IDX][MODE_FIELD_LSB +: 2]);
    assign eff_idx = (mode == MAP_BASE) ? {1'b0, index_q[BASE_W-1:0]}
                                        : index_q[IDX_W-1:0];
    assign win_sel = ireg_q[WIN_REG_IDX][XSEL_W-1:0];

    assign dp_wr   = commit && (off == OFF_DATA) && !redirect;
    assign leaving = dp_wr && (eff_idx == IDX_W'(MODE_REG_IDX)) && (mode != MAP_BASE) &&
                     (decode_map(wr_val[MODE_FIELD_LSB +: 2]) == MAP_BASE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q  <= '0;
            stat_q   <= '0;
            direct_q <= '0;
            for (int i = 0; i < N_IDX; i++) ireg_q[i] <= '0;
        end else begin
            if (commit && off == OFF_INDEX)  index_q  <= wr_val;
            if (commit && off == OFF_STAT)   stat_q   <= wr_val;
            if (commit && off == OFF_DIRECT) direct_q <= wr_val;
            for (int i = 0; i < N_IDX; i++) begin
                if (dp_wr && eff_idx == IDX_W'(i))
                    ireg_q[i] <= wr_val;
                else if (leaving && CLR_ON_BASE[i])
                    ireg_q[i] <= '0;
            end
        end
    end

    always_comb begin
        unique case (off)
            OFF_INDEX: rd_val = index_q;
            OFF_DATA:  rd_val = ireg_q[eff_idx];
            OFF_STAT:  rd_val = stat_q;
            default:   rd_val = direct_q;
        endcase
    end

endmodule

// File: rtl/codec_regif_xwin.sv
module codec_regif_xwin
    import codec_regif_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_X    = 32,
    parameter int IDX_W  = 5,
    parameter int XSEL_W = $clog2(N_X)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  map_mode_e         mode,
    input  logic              commit,
    input  logic              rd_done,
    input  logic [1:0]        off,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [IDX_W-1:0]  eff_idx,
    input  logic [XSEL_W-1:0] win_sel,
    output logic              armed,
    output logic [DATA_W-1:0] x_rd
);

    logic [DATA_W-1:0] xreg_q [N_X];
    logic              arm_q, dp_commit, dp_rd_end, arm_set;

    assign dp_commit = commit && (off == OFF_DATA);
    assign dp_rd_end = rd_done && (off == OFF_DATA);
    assign arm_set   = dp_commit && !arm_q && (mode == MAP_EXT) &&
                       (eff_idx == IDX_W'(WIN_REG_IDX)) && wr_val[WIN_ARM_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
            for (int i = 0; i < N_X; i++) xreg_q[i] <= '0;
        end else begin
            if (arm_set)
                arm_q <= 1'b1;
            else if (arm_q && (dp_commit || dp_rd_end))
                arm_q <= 1'b0;
            if (arm_q && dp_commit)
                xreg_q[win_sel] <= wr_val;
        end
    end

    assign armed = arm_q;
    assign x_rd  = xreg_q[win_sel];

endmodule

// File: rtl/codec_regif.sv
module codec_regif
    import codec_regif_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int N_IDX  = 32,
    parameter int N_X    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              aen,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);

    localparam int IDX_W  = $clog2(N_IDX);
    localparam int XSEL_W = $clog2(N_X);

    logic              drive_en, commit_w, rd_done_w, armed_w;
    logic [1:0]        cur_off;
    logic [DATA_W-1:0] wr_val, bank_rd, x_rd;
    logic [IDX_W-1:0]  eff_idx;
    logic [XSEL_W-1:0] win_sel;
    map_mode_e         mode_w;

    codec_regif_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .base_addr(base_addr),
        .aen(aen), .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata),
        .drive_en(drive_en), .cur_off(cur_off), .commit(commit_w),
        .rd_done(rd_done_w), .wr_val(wr_val)
    );

    codec_regif_bank #(.DATA_W(DATA_W), .N_IDX(N_IDX), .N_X(N_X)) u_bank (
        .clk(clk), .rst_n(rst_n), .commit(commit_w), .off(cur_off),
        .wr_val(wr_val), .redirect(armed_w), .rd_val(bank_rd),
        .mode(mode_w), .eff_idx(eff_idx), .win_sel(win_sel)
    );

    codec_regif_xwin #(.DATA_W(DATA_W), .N_X(N_X), .IDX_W(IDX_W)) u_xwin (
        .clk(clk), .rst_n(rst_n), .mode(mode_w), .commit(commit_w),
        .rd_done(rd_done_w), .off(cur_off), .wr_val(wr_val),
        .eff_idx(eff_idx), .win_sel(win_sel), .armed(armed_w), .x_rd(x_rd)
    );

    assign rdata_oe = drive_en;
    assign rdata    = !drive_en ? '0 :
                      (cur_off == OFF_DATA && armed_w) ? x_rd : bank_rd;

endmodule

// File: rtl/codec_regif_chk.sv
module codec_regif_chk
    import codec_regif_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [ADDR_W-1:0] base_addr,
    input logic              aen,
    input logic              rd_n,
    input logic              wr_n,
    input logic              rdata_oe,
    input logic              commit,
    input logic              armed,
    input logic [1:0]        dp_off,
    input map_mode_e         mode,
    input logic [DATA_W-1:0] r24,
    input logic [DATA_W-1:0] r28,
    input logic [DATA_W-1:0] r30,
    input logic [DATA_W-1:0] r31
);

    logic sel_ok;
    assign sel_ok = (bus_addr[ADDR_W-1:2] == base_addr[ADDR_W-1:2]);

    assert_oe_after_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdata_oe) |-> $past(!rd_n && !aen && sel_ok));

    assert_oe_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && rd_n) |=> !rdata_oe);

    assert_commit_after_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(wr_n) && !$past(wr_n, 2)));

    assert_clear_on_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MAP_BASE && $past(mode) != MAP_BASE) |->
        (r24 == '0 && r28 == '0 && r30 == '0 && r31 == '0));

    assert_arm_in_ext_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> (mode == MAP_EXT));

    assert_arm_consumed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && commit && dp_off == OFF_DATA) |=> !armed);

endmodule

bind codec_regif codec_regif_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .base_addr(base_addr),
    .aen(aen), .rd_n(rd_n), .wr_n(wr_n), .rdata_oe(rdata_oe),
    .commit(commit_w), .armed(armed_w), .dp_off(cur_off), .mode(mode_w),
    .r24(u_bank.ireg_q[24]), .r28(u_bank.ireg_q[28]),
    .r30(u_bank.ireg_q[30]), .r31(u_bank.ireg_q[31])
);

// File: tb/codec_regif_bench.sv
module codec_regif_bench;

    localparam logic [9:0] BASE = 10'h134;
    localparam logic       WR = 1'b0;
    localparam logic       RD = 1'b1;

    typedef struct packed {
        logic       rd;
        logic [1:0] off;
        logic [7:0] val;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 72;
    localparam vec_t VT [NV] = '{
        '{WR, 2'd2, 8'h3C, 4'd5},  '{RD, 2'd2, 8'h3C, 4'd5},   // R5 status latch
        '{WR, 2'd3, 8'hC3, 4'd5},  '{RD, 2'd3, 8'hC3, 4'd5},   // R5 direct latch
        '{WR, 2'd0, 8'h13, 4'd7},  '{RD, 2'd0, 8'h13, 4'd7},   // R7 pointer readback
        '{WR, 2'd1, 8'hA5, 4'd7},  '{WR, 2'd0, 8'h03, 4'd7},
        '{RD, 2'd1, 8'hA5, 4'd7},                              // R7 0x13 hit reg 3
        '{WR, 2'd0, 8'h0C, 4'd6},  '{WR, 2'd1, 8'h80, 4'd6},
        '{RD, 2'd1, 8'h80, 4'd6},                              // R6 wide map
        '{WR, 2'd0, 8'h13, 4'd8},  '{RD, 2'd1, 8'h00, 4'd8},   // R8 reg 19 blank
        '{WR, 2'd0, 8'hF3, 4'd8},  '{WR, 2'd1, 8'h19, 4'd8},
        '{WR, 2'd0, 8'h13, 4'd8},  '{RD, 2'd1, 8'h19, 4'd8},   // R8 bits 7:5 ignored
        '{WR, 2'd0, 8'h18, 4'd9},  '{WR, 2'd1, 8'h11, 4'd9},
        '{WR, 2'd0, 8'h19, 4'd9},  '{WR, 2'd1, 8'h22, 4'd9},
        '{WR, 2'd0, 8'h1C, 4'd9},  '{WR, 2'd1, 8'h33, 4'd9},
        '{WR, 2'd0, 8'h1E, 4'd9},  '{WR, 2'd1, 8'h44, 4'd9},
        '{WR, 2'd0, 8'h1F, 4'd9},  '{WR, 2'd1, 8'h55, 4'd9},
        '{WR, 2'd0, 8'h10, 4'd9},  '{WR, 2'd1, 8'h66, 4'd9},
        '{WR, 2'd0, 8'h17, 4'd11}, '{WR, 2'd1, 8'h85, 4'd11},
        '{WR, 2'd1, 8'h77, 4'd11}, '{RD, 2'd1, 8'h77, 4'd11},  // R11 no window in wide map
        '{WR, 2'd0, 8'h0C, 4'd6},  '{WR, 2'd1, 8'h40, 4'd6},
        '{RD, 2'd1, 8'h40, 4'd6},                              // R6 field 01 reads back
        '{WR, 2'd0, 8'h13, 4'd6},  '{RD, 2'd1, 8'hA5, 4'd6},   // R6 01 acts as base map
        '{WR, 2'd0, 8'h0C, 4'd9},  '{WR, 2'd1, 8'h80, 4'd9},
        '{WR, 2'd0, 8'h18, 4'd9},  '{RD, 2'd1, 8'h00, 4'd9},   // R9 reg 24 cleared
        '{WR, 2'd0, 8'h19, 4'd9},  '{RD, 2'd1, 8'h22, 4'd9},   // R9 reg 25 kept
        '{WR, 2'd0, 8'h1C, 4'd9},  '{RD, 2'd1, 8'h00, 4'd9},   // R9 reg 28 cleared
        '{WR, 2'd0, 8'h1E, 4'd9},  '{RD, 2'd1, 8'h00, 4'd9},   // R9 reg 30 cleared
        '{WR, 2'd0, 8'h1F, 4'd9},  '{RD, 2'd1, 8'h00, 4'd9},   // R9 reg 31 cleared
        '{WR, 2'd0, 8'h10, 4'd9},  '{RD, 2'd1, 8'h66, 4'd9},   // R9 reg 16 kept
        '{WR, 2'd0, 8'h17, 4'd9},  '{RD, 2'd1, 8'h77, 4'd9},   // R9 reg 23 kept
        '{WR, 2'd0, 8'h0C, 4'd6},  '{WR, 2'd1, 8'hC0, 4'd6},
        '{RD, 2'd1, 8'hC0, 4'd6},                              // R6 extended map
        '{WR, 2'd0, 8'h17, 4'd10}, '{WR, 2'd1, 8'h85, 4'd10},  // R10 arm, select X5
        '{WR, 2'd1, 8'h5A, 4'd10}, '{RD, 2'd1, 8'h85, 4'd10},  // R10 write went to X5
        '{WR, 2'd1, 8'h85, 4'd10}, '{RD, 2'd1, 8'h5A, 4'd10},  // R10 read X5
        '{RD, 2'd1, 8'h85, 4'd10},                             // R10 disarmed
        '{WR, 2'd1, 8'h06, 4'd11}, '{RD, 2'd1, 8'h06, 4'd11},  // R11 bit 7 clear
        '{WR, 2'd0, 8'h0C, 4'd6},  '{WR, 2'd1, 8'h00, 4'd6},
        '{RD, 2'd1, 8'h00, 4'd6},                              // R6 back to base map
        '{WR, 2'd0, 8'h17, 4'd7},  '{RD, 2'd1, 8'h00, 4'd7}    // R7 0x17 hits reg 7
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] bus_addr = '0;
    logic [9:0] base_addr = BASE;
    logic       aen = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    codec_regif u_codec_regif (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .base_addr(base_addr),
        .aen(aen), .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic aen_v,
                             input logic [7:0] d, input logic [7:0] d_late);
        @(negedge clk);
        bus_addr = a; aen = aen_v; wr_n = 1'b0; wdata = d;
        @(negedge clk);
        wr_n = 1'b1; wdata = d_late;
        @(negedge clk);
        @(negedge clk);
        aen = 1'b1;
    endtask

    task automatic bus_read(input logic [9:0] a, input logic aen_v,
                            output logic [7:0] v, output logic oe_mid,
                            output logic oe_after);
        @(negedge clk);
        bus_addr = a; aen = aen_v; rd_n = 1'b0;
        @(negedge clk);
        v = rdata; oe_mid = rdata_oe;
        rd_n = 1'b1;
        @(negedge clk);
        oe_after = rdata_oe;
        aen = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic       om, oa;

        // R1: output enable held low during reset
        repeat (3) @(negedge clk);
        check(1, {7'd0, rdata_oe}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, {7'd0, rdata_oe}, 8'h00);
        for (int k = 0; k < 4; k++) begin
            bus_read(BASE | 10'(k), 1'b0, v, om, oa);
            check(1, v, 8'h00);   // R1 reset values
        end

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VT[i].rd) begin
                bus_read(BASE | 10'(VT[i].off), 1'b0, v, om, oa);
                check(int'(VT[i].req), v, VT[i].val);
            end else begin
                bus_write(BASE | 10'(VT[i].off), 1'b0, VT[i].val, VT[i].val);
            end
        end

        // R3: enable timing around a read
        bus_read(BASE | 10'd2, 1'b0, v, om, oa);
        check(3, {7'd0, om}, 8'h01);
        check(3, {7'd0, oa}, 8'h00);
        check(3, v, 8'h3C);

        // R4: data changed with the rising strobe is not stored
        bus_write(BASE | 10'd3, 1'b0, 8'h5E, 8'hA1);
        bus_read(BASE | 10'd3, 1'b0, v, om, oa);
        check(4, v, 8'h5E);

        // R2: write with aen high is ignored
        bus_write(BASE | 10'd2, 1'b1, 8'hEE, 8'hEE);
        bus_read(BASE | 10'd2, 1'b0, v, om, oa);
        check(2, v, 8'h3C);

        // R2: write to a different base is ignored
        bus_write((BASE + 10'h004) | 10'd2, 1'b0, 8'hEE, 8'hEE);
        bus_read(BASE | 10'd2, 1'b0, v, om, oa);
        check(2, v, 8'h3C);

        // R2: read with aen high never drives
        bus_read(BASE | 10'd2, 1'b1, v, om, oa);
        check(2, {7'd0, om}, 8'h00);
        check(2, {7'd0, oa}, 8'h00);

        // R2: base low bits ignored
        base_addr = BASE | 10'd3;
        bus_read(BASE | 10'd3, 1'b0, v, om, oa);
        check(2, v, 8'h5E);
        base_addr = BASE;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule